// File: doc/BRIEF.md
# Programmable Bus Strobe Pattern Sequencer

This block is a small microcoded engine that shapes the chip-select, write-enable and output-enable strobes of an external peripheral. Each bus access steps through a short program of 32-bit pattern words kept in a 64-word internal RAM. Each word sets the strobe levels at quarter-clock resolution for as many bus clocks as its repeat field asks, and carries controls for looping, wait-pin stalls, transfer-acknowledge and end of pattern.

Software sets the operation, the wait polarity, two loop counts and a RAM address in a mode register, and puts a word in a data register. In the store operation each access request writes the data register into the RAM at the mode address and then advances the address. In the fetch operation each request loads the addressed RAM word into the data register and advances the address. Software polls the address field to see that the transfer is complete. In the normal operation a request runs the read pattern (word 0) or the write pattern (word 24). In the run operation a request runs the pattern that starts at the mode address. A one-cycle done pulse marks the end of a pattern.

Top module: `bus_pattern_seq`

## Requirements
- R1: After reset csN reads 4'hF, weN 4'hF, oeN 2'b11, ackOut and doneOut 0, and both modeValue and dataValue are zero.
- R2: With the mode op field (bits 29:28) at 2'b01, an accepted request stores dataValue at the RAM address in mode bits 5:0 and increments that field on the same clock edge, wrapping from 63 to 0.
- R3: With the op field at 2'b10, an accepted request loads the RAM word at mode bits 5:0 into dataValue and increments the address field.
- R4: After reset every RAM word holds the idle terminator 32'hFFF3_0001.
- R5: With the op field at 2'b00 a request runs from word 0 when accWrite is 0 and from word 24 when it is 1. With 2'b11 it runs from the address in mode bits 5:0.
- R6: While a word executes, csN shows word bits 31:28, weN bits 27:24, oeN bits 17:16 and ackOut bit 2. In each field the higher bit is the earlier quarter or half. When no pattern runs, the strobes are all high and ackOut is 0.
- R7: A word stays active for (bits 9:8)+1 bus clocks before any wait stall.
- R8: Bit 7 marks a loop boundary. The words from the first marked word through the next marked word run N times. N is taken from mode bits 17:14 when accWrite was 0 at the start and from bits 13:10 when it was 1, and a field of 0 means 16.
- R9: A word with bit 12 set holds at its last repeat clock while the wait input is active and moves on at the first clock edge where it is inactive. Mode bit 27 set makes waitIn active-low, clear makes it active-high.
- R10: Bit 0 ends the pattern after that word. doneOut is high for exactly the next cycle, and the strobes return to idle.
- R11: A request that arrives while a pattern runs is ignored. A request is accepted only when no pattern runs, which includes the cycle where doneOut is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the mode register, 1 the data register |
| regWrData | input | 32 | Register write value |
| modeValue | output | 32 | Current mode register |
| dataValue | output | 32 | Current data register |
| accReq | input | 1 | Access request |
| accWrite | input | 1 | 1 picks the write pattern and write loop count |
| waitIn | input | 1 | Peripheral wait pin |
| csN | output | 4 | Chip-select levels per quarter clock, bit 3 first |
| weN | output | 4 | Write-enable levels per quarter clock, bit 3 first |
| oeN | output | 2 | Output-enable levels per half clock, bit 1 first |
| ackOut | output | 1 | Transfer-acknowledge |
| doneOut | output | 1 | One-cycle end-of-pattern pulse |

## Verification
An accepted request at a clock edge brings the first pattern word onto the strobes right after that edge. Register and RAM-access results appear after the same edge. doneOut follows one cycle after the clock of the last word. The bench drives every input just after a falling edge. At the next falling edge, before it drives again, it compares all outputs with a cycle model that it advances on each clock edge. Pattern lengths worked out by hand for the repeat, loop and wait cases are checked by counting falling edges from acceptance to doneOut.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int ADDR_W = 6;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = 32;
  localparam int LOOP_W = 4;
  localparam int REP_W = 2;
  localparam logic [WORD_W-1:0] IDLE_WORD = 32'hFFF3_0001;

  typedef enum logic [1:0] {
    OP_NORMAL = 2'b00,
    OP_STORE  = 2'b01,
    OP_FETCH  = 2'b10,
    OP_RUN    = 2'b11
  } opKind_e;

  typedef struct packed {
    opKind_e           op;
    logic              waitLow;
    logic [LOOP_W-1:0] rdLoop;
    logic [LOOP_W-1:0] wrLoop;
    logic [ADDR_W-1:0] addr;
  } modeView_t;

  typedef struct packed {
    logic [3:0]       cs;
    logic [3:0]       we;
    logic [1:0]       oe;
    logic             waitEn;
    logic [REP_W-1:0] rep;
    logic             loopMark;
    logic             ack;
    logic             last;
  } patWord_t;

  typedef struct packed {
    logic              storeEn;
    logic              loadEn;
    logic [ADDR_W-1:0] fetchAddr;
  } dpCtl_t;
endpackage

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [WORD_W-1:0] regWrData,
  input  dpCtl_t            ctl,
  output logic [WORD_W-1:0] modeReg,
  output logic [WORD_W-1:0] dataReg,
  output modeView_t         modeView,
  output patWord_t          curWord
);
  logic [WORD_W-1:0] ram [DEPTH];
  logic [ADDR_W-1:0] ramAddr;
  logic [WORD_W-1:0] fetched;

  assign ramAddr = modeReg[ADDR_W-1:0];
  assign fetched = ram[ctl.fetchAddr];

  assign modeView.op      = opKind_e'(modeReg[29:28]);
  assign modeView.waitLow = modeReg[27];
  assign modeView.rdLoop  = modeReg[17:14];
  assign modeView.wrLoop  = modeReg[13:10];
  assign modeView.addr    = ramAddr;

  assign curWord.cs       = fetched[31:28];
  assign curWord.we       = fetched[27:24];
  assign curWord.oe       = fetched[17:16];
  assign curWord.waitEn   = fetched[12];
  assign curWord.rep      = fetched[9:8];
  assign curWord.loopMark = fetched[7];
  assign curWord.ack      = fetched[2];
  assign curWord.last     = fetched[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      dataReg <= '0;
      for (int i = 0; i < DEPTH; i++) ram[i] <= IDLE_WORD;
    end else begin
      if (ctl.storeEn) ram[ramAddr] <= dataReg;
      if (ctl.loadEn) dataReg <= ram[ramAddr];
      if (ctl.storeEn || ctl.loadEn) modeReg[ADDR_W-1:0] <= ramAddr + 1'b1;
      if (regWrEn) begin
        if (regSel) dataReg <= regWrData;
        else modeReg <= regWrData;
      end
    end
  end
endmodule

// File: rtl/bps_control.sv
module bps_control
  import bps_pkg::*;
#(
  parameter int RD_START = 0,
  parameter int WR_START = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      accReq,
  input  logic      accWrite,
  input  logic      waitIn,
  input  modeView_t mode,
  input  patWord_t  word,
  output dpCtl_t    ctl,
  output logic [3:0] csN,
  output logic [3:0] weN,
  output logic [1:0] oeN,
  output logic      ackOut,
  output logic      doneOut,
  output logic      busy
);
  localparam logic [ADDR_W-1:0] RD_PC = ADDR_W'(RD_START);
  localparam logic [ADDR_W-1:0] WR_PC = ADDR_W'(WR_START);

  logic              running;
  logic [ADDR_W-1:0] pc;
  logic [REP_W-1:0]  repCnt;
  logic              inLoop;
  logic [ADDR_W-1:0] loopStart;
  logic [LOOP_W:0]   loopRem;
  logic              wrPat;

  logic              waitActive;
  logic              wordEnd;
  logic              startReq;
  logic [ADDR_W-1:0] startPc;
  logic [LOOP_W-1:0] loopField;
  logic [LOOP_W:0]   loopN;

  assign waitActive = mode.waitLow ? !waitIn : waitIn;
  assign wordEnd    = (repCnt == word.rep) && !(word.waitEn && waitActive);
  assign startReq   = !running && accReq && (mode.op == OP_NORMAL || mode.op == OP_RUN);
  assign startPc    = (mode.op == OP_RUN) ? mode.addr : (accWrite ? WR_PC : RD_PC);
  assign loopField  = wrPat ? mode.wrLoop : mode.rdLoop;
  assign loopN      = (loopField == '0) ? (LOOP_W+1)'(1 << LOOP_W) : {1'b0, loopField};

  assign ctl.storeEn   = !running && accReq && mode.op == OP_STORE;
  assign ctl.loadEn    = !running && accReq && mode.op == OP_FETCH;
  assign ctl.fetchAddr = pc;

  assign csN    = running ? word.cs : 4'hF;
  assign weN    = running ? word.we : 4'hF;
  assign oeN    = running ? word.oe : 2'b11;
  assign ackOut = running && word.ack;
  assign busy   = running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      pc        <= '0;
      repCnt    <= '0;
      inLoop    <= 1'b0;
      loopStart <= '0;
      loopRem   <= '0;
      wrPat     <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (startReq) begin
        running <= 1'b1;
        pc      <= startPc;
        repCnt  <= '0;
        inLoop  <= 1'b0;
        wrPat   <= accWrite;
      end else if (running) begin
        if (!wordEnd) begin
          if (repCnt != word.rep) repCnt <= repCnt + 1'b1;
        end else begin
          repCnt <= '0;
          if (word.last) begin
            running <= 1'b0;
            doneOut <= 1'b1;
            inLoop  <= 1'b0;
          end else if (word.loopMark && !inLoop) begin
            inLoop    <= 1'b1;
            loopStart <= pc;
            loopRem   <= loopN;
            pc        <= pc + 1'b1;
          end else if (word.loopMark && inLoop && pc != loopStart) begin
            if (loopRem > 1) begin
              loopRem <= loopRem - 1'b1;
              pc      <= loopStart;
            end else begin
              inLoop <= 1'b0;
              pc     <= pc + 1'b1;
            end
          end else begin
            pc <= pc + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bus_pattern_seq.sv
module bus_pattern_seq
  import bps_pkg::*;
#(
  parameter int RD_START = 0,
  parameter int WR_START = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] modeValue,
  output logic [31:0] dataValue,
  input  logic        accReq,
  input  logic        accWrite,
  input  logic        waitIn,
  output logic [3:0]  csN,
  output logic [3:0]  weN,
  output logic [1:0]  oeN,
  output logic        ackOut,
  output logic        doneOut
);
  dpCtl_t    dpCtl;
  modeView_t modeView;
  patWord_t  curWord;
  logic      ctlBusy;

  bps_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ctl(dpCtl), .modeReg(modeValue),
    .dataReg(dataValue), .modeView(modeView), .curWord(curWord)
  );

  bps_control #(.RD_START(RD_START), .WR_START(WR_START)) u_ctl (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accWrite(accWrite),
    .waitIn(waitIn), .mode(modeView), .word(curWord), .ctl(dpCtl),
    .csN(csN), .weN(weN), .oeN(oeN), .ackOut(ackOut),
    .doneOut(doneOut), .busy(ctlBusy)
  );
endmodule

// File: rtl/bps_checker.sv
module bps_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        accReq,
  input logic [31:0] modeValue,
  input logic [3:0]  csN,
  input logic [3:0]  weN,
  input logic [1:0]  oeN,
  input logic        ackOut,
  input logic        doneOut,
  input logic        busy
);
  a_r2_store_advances: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && !busy && !regWrEn && modeValue[29:28] == 2'b01)
      |=> modeValue[5:0] == 6'($past(modeValue[5:0]) + 6'd1));

  a_r3_fetch_advances: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && !busy && !regWrEn && modeValue[29:28] == 2'b10)
      |=> modeValue[5:0] == 6'($past(modeValue[5:0]) + 6'd1));

  a_r6_idle_levels: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN == 4'hF && weN == 4'hF && oeN == 2'b11 && !ackOut));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busy);

  a_r11_no_ram_op_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !regWrEn) |=> $stable(modeValue));
endmodule

bind bus_pattern_seq bps_checker u_bps_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .accReq(accReq),
  .modeValue(modeValue), .csN(csN), .weN(weN), .oeN(oeN),
  .ackOut(ackOut), .doneOut(doneOut), .busy(ctlBusy)
);

// File: tb/test_bus_pattern_seq.sv
module test_bus_pattern_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDLE_W = 32'hFFF3_0001;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regSel = 0, accReq = 0, accWrite = 0, waitIn = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] modeValue, dataValue;
  logic [3:0] csN, weN;
  logic [1:0] oeN;
  logic ackOut, doneOut;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic lastDone;

  // bench-side state
  logic [31:0] bRam [64];
  logic [31:0] mMode, mData;
  logic mRun, mInLoop, mWrPat, mDone;
  logic [5:0] mPc, mLoopStart;
  logic [1:0] mRep;
  int mRem;
  logic bWaitLow;
  logic [3:0] bLoopR, bLoopW;

  bus_pattern_seq i_bus_pattern_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .modeValue(modeValue), .dataValue(dataValue),
    .accReq(accReq), .accWrite(accWrite), .waitIn(waitIn), .csN(csN),
    .weN(weN), .oeN(oeN), .ackOut(ackOut), .doneOut(doneOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkMode(input logic [1:0] op, input logic [5:0] addr);
    return {2'b00, op, bWaitLow, 9'b0, bLoopR, bLoopW, 4'b0, addr};
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] cs, input logic [3:0] we,
      input logic [1:0] oe, input logic wt, input logic [1:0] rep, input logic lp,
      input logic ack, input logic last);
    return {cs, we, 6'b111100, oe, 3'b000, wt, 2'b00, rep, lp, 4'b0000, ack, 1'b0, last};
  endfunction

  // One clock: check outputs at the falling edge, drive inputs, advance the model.
  task automatic cycle(input logic req, input logic wr, input logic wt,
                       input logic rEn, input logic rSel, input logic [31:0] rData);
    logic [31:0] w;
    logic waitAct, nDone;
    logic [3:0] lf;
    int n;
    @(negedge clk);
    w = bRam[mPc];
    lastDone = doneOut;
    chk(csN == (mRun ? w[31:28] : 4'hF), "R6", "csN", csN, mRun ? w[31:28] : 4'hF);
    chk(weN == (mRun ? w[27:24] : 4'hF), "R6", "weN", weN, mRun ? w[27:24] : 4'hF);
    chk(oeN == (mRun ? w[17:16] : 2'b11), "R6", "oeN", oeN, mRun ? w[17:16] : 2'b11);
    chk(ackOut == (mRun && w[2]), "R6", "ackOut", ackOut, mRun && w[2]);
    chk(doneOut == mDone, "R10", "doneOut", doneOut, mDone);
    chk(modeValue == mMode, "R2", "modeValue", modeValue, mMode);
    chk(dataValue == mData, "R3", "dataValue", dataValue, mData);
    accReq = req; accWrite = wr; waitIn = wt;
    regWrEn = rEn; regSel = rSel; regWrData = rData;
    nDone = 0;
    if (mRun) begin
      waitAct = mMode[27] ? !wt : wt;
      if (mRep != w[9:8]) mRep++;
      else if (w[12] && waitAct) begin end
      else begin
        mRep = 0;
        lf = mWrPat ? mMode[13:10] : mMode[17:14];
        n = (lf == 0) ? 16 : int'(lf);
        if (w[0]) begin mRun = 0; nDone = 1; mInLoop = 0; end
        else if (w[7] && !mInLoop) begin mInLoop = 1; mLoopStart = mPc; mRem = n; mPc++; end
        else if (w[7] && mInLoop && mPc != mLoopStart) begin
          if (mRem > 1) begin mRem--; mPc = mLoopStart; end
          else begin mInLoop = 0; mPc++; end
        end else mPc++;
      end
    end else if (req) begin
      case (mMode[29:28])
        2'b01: begin bRam[mMode[5:0]] = mData; mMode[5:0] = mMode[5:0] + 1; end
        2'b10: begin mData = bRam[mMode[5:0]]; mMode[5:0] = mMode[5:0] + 1; end
        default: begin
          mRun = 1; mRep = 0; mInLoop = 0; mWrPat = wr;
          mPc = (mMode[29:28] == 2'b11) ? mMode[5:0] : (wr ? 6'd24 : 6'd0);
        end
      endcase
    end
    if (rEn) begin
      if (rSel) mData = rData; else mMode = rData;
    end
    mDone = nDone;
  endtask

  task automatic idleCycle();
    cycle(0, 0, bWaitLow, 0, 0, 0);
  endtask

  task automatic setMode(input logic [1:0] op, input logic [5:0] addr);
    cycle(0, 0, bWaitLow, 1, 0, mkMode(op, addr));
  endtask

  task automatic storeWord(input logic [5:0] addr, input logic [31:0] val);
    setMode(2'b01, addr);
    cycle(0, 0, bWaitLow, 1, 1, val);
    cycle(1, 0, bWaitLow, 0, 0, 0);
  endtask

  // Start a pattern and count falling edges until doneOut; length = edges - 1.
  task automatic runTimed(input logic wr, input int holdReq, input int stallN,
                          input int expL, input string tag);
    int k;
    logic act;
    cycle(1, wr, bWaitLow, 0, 0, 0);
    k = 0;
    lastDone = 0;
    while (!lastDone && k < 300) begin
      k++;
      act = (k <= stallN);
      cycle(k <= holdReq, wr, bWaitLow ? !act : act, 0, 0, 0);
    end
    chk(k - 1 == expL, tag, "pattern length", k - 1, expL);
    idleCycle();
  endtask

  task automatic runRandom(input logic wr);
    int k;
    cycle(1, wr, $urandom_range(0, 1), 0, 0, 0);
    k = 0;
    lastDone = 0;
    while (!lastDone && k < 300) begin
      k++;
      cycle($urandom_range(0, 3) == 0, wr, $urandom_range(0, 2) == 0, 0, 0, 0);
    end
    chk(lastDone == 1, "R10", "random pattern finished", lastDone, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    if (!finished) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) bRam[i] = IDLE_W;
    mMode = 0; mData = 0; mRun = 0; mInLoop = 0; mWrPat = 0; mDone = 0;
    mPc = 0; mLoopStart = 0; mRep = 0; mRem = 0;
    bWaitLow = 0; bLoopR = 4'd3; bLoopW = 4'd0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(csN == 4'hF && weN == 4'hF && oeN == 2'b11, "R1", "reset strobes", {csN, weN, oeN}, 10'h3FF);
    chk(!ackOut && !doneOut, "R1", "reset ack/done", {ackOut, doneOut}, 0);
    chk(modeValue == 0 && dataValue == 0, "R1", "reset registers", modeValue | dataValue, 0);

    // R4: fetch words after reset
    setMode(2'b10, 6'd5);
    cycle(1, 0, 0, 0, 0, 0);
    idleCycle();
    chk(dataValue == IDLE_W, "R4", "reset RAM word 5", dataValue, IDLE_W);
    chk(modeValue[5:0] == 6'd6, "R3", "fetch advances address", modeValue[5:0], 6);

    // R2: store wraps address from 63 to 0
    storeWord(6'd63, 32'hA5A5_0000);
    idleCycle();
    chk(modeValue[5:0] == 6'd0, "R2", "store wrap", modeValue[5:0], 0);
    setMode(2'b10, 6'd63);
    cycle(1, 0, 0, 0, 0, 0);
    idleCycle();
    chk(dataValue == 32'hA5A5_0000, "R3", "fetch stored word", dataValue, 32'hA5A5_0000);

    // R5/R7/R11: read pattern at 0, write pattern at 24
    storeWord(6'd0, mkWord(4'h3, 4'hF, 2'b01, 0, 2'd2, 0, 0, 0));
    storeWord(6'd1, mkWord(4'h0, 4'hF, 2'b00, 0, 2'd0, 0, 1, 1));
    storeWord(6'd24, mkWord(4'h7, 4'hE, 2'b11, 0, 2'd3, 0, 0, 0));
    storeWord(6'd25, mkWord(4'h0, 4'h0, 2'b11, 0, 2'd1, 0, 1, 0));
    storeWord(6'd26, mkWord(4'hC, 4'hF, 2'b11, 0, 2'd0, 0, 0, 1));
    setMode(2'b00, 6'd0);
    runTimed(0, 3, 0, 4, "R11");
    runTimed(0, 0, 0, 4, "R7");
    runTimed(1, 0, 0, 7, "R5");

    // R8: loop at words 40..44, run operation
    storeWord(6'd40, mkWord(4'hE, 4'hF, 2'b11, 0, 2'd0, 0, 0, 0));
    storeWord(6'd41, mkWord(4'h0, 4'hF, 2'b10, 0, 2'd0, 1, 0, 0));
    storeWord(6'd42, mkWord(4'h0, 4'hF, 2'b00, 0, 2'd0, 0, 1, 0));
    storeWord(6'd43, mkWord(4'h1, 4'hF, 2'b11, 0, 2'd0, 1, 0, 0));
    storeWord(6'd44, mkWord(4'hF, 4'hF, 2'b11, 0, 2'd0, 0, 0, 1));
    setMode(2'b11, 6'd40);
    runTimed(0, 0, 0, 11, "R8");
    runTimed(1, 0, 0, 50, "R8");

    // R9: wait stall, active-low then active-high
    storeWord(6'd48, mkWord(4'h0, 4'hF, 2'b00, 1, 2'd0, 0, 0, 0));
    storeWord(6'd49, mkWord(4'hF, 4'hF, 2'b11, 0, 2'd0, 0, 1, 1));
    bWaitLow = 1;
    setMode(2'b11, 6'd48);
    runTimed(0, 0, 3, 5, "R9");
    bWaitLow = 0;
    setMode(2'b11, 6'd48);
    runTimed(0, 0, 0, 2, "R9");
    runTimed(0, 0, 2, 4, "R9");

    // Random patterns checked cycle by cycle against the model
    for (int it = 0; it < 40; it++) begin
      int lenR, lenW;
      logic [31:0] r;
      lenR = $urandom_range(1, 6);
      lenW = $urandom_range(1, 6);
      for (int j = 0; j < lenR; j++) begin
        r = $urandom & 32'hFFFF_FF7E;
        storeWord(6'(j), r | 32'(j == lenR - 1));
      end
      for (int j = 0; j < lenW; j++) begin
        r = $urandom & 32'hFFFF_FF7E;
        storeWord(6'(24 + j), r | 32'(j == lenW - 1));
      end
      bWaitLow = $urandom_range(0, 1);
      setMode(2'b00, 6'($urandom_range(0, 63)));
      runRandom(0);
      runRandom(1);
      idleCycle();
    end
    idleCycle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule